// File: doc/BRIEF.md
# Request-Acknowledge-Write Handshake Monitor

This block watches a handshake as it happens. An attempt opens when request rises in an idle cycle. Request may stay high for any number of cycles. The cycle after the request run must carry acknowledge. A run of write cycles of fixed length, `WR_LEN` (four by default), then has to follow. Once that run has been seen, the monitor checks the obligation in the following cycles. Any number of cycles with wait high and request low may pass, and then done must arrive.

An attempt that stops matching before the write run is complete is dropped without any report. Only a broken obligation raises the fail pulse, and a met obligation raises the pass pulse. The monitor tracks one attempt at a time. The active output tells the surrounding logic that an attempt is open.

The monitor is meant to sit beside a bus or handshake controller in silicon. It gives a pass and fail verdict at run time, with no simulator-only constructs.

Top module: `reqack_write_monitor`

## Requirements
- R1: A cycle with `rst` high clears the monitor. In the following cycle `active`, `passPulse` and `failPulse` are all 0, and it sits idle until a fresh request arrives.
- R2: In idle, a cycle with `reqIn` high opens an attempt, so `active` is 1 from the next cycle. Any number of further request cycles keep it open.
- R3: In the cycle after the last request cycle, `ackIn` must be high. If that cycle has neither acknowledge nor request, the attempt is dropped silently: `active` returns to 0 and no fail is raised. When acknowledge and request are both high, acknowledge takes priority.
- R4: The `WR_LEN` cycles (default 4) that follow the acknowledge cycle must all have `wrIn` high. A cycle with `wrIn` low inside that run drops the attempt silently.
- R5: The obligation is checked from the cycle after the last write cycle of the run. Done in that very cycle gives a pass, so zero wait cycles are allowed.
- R6: Before done, any number of cycles with `waitIn` high and `reqIn` low are accepted, and `active` stays 1 through them.
- R7: A cycle with `doneIn` high ends the obligation with a pass, whether or not `waitIn` is also high.
- R8: While the obligation is checked, a cycle that has no done and is not a wait-without-request cycle raises fail and closes the attempt. Examples are a further write cycle, an empty cycle, and wait together with request.
- R9: Pass and fail are registered pulses of one cycle. Each appears in the cycle after the deciding input cycle, with `active` already 0, and the two are never high together.
- R10: While an attempt is open, `reqIn` starts no new attempt and does not disturb the count of write cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| reqIn | input | 1 | Request |
| ackIn | input | 1 | Acknowledge |
| wrIn | input | 1 | Write |
| waitIn | input | 1 | Wait |
| doneIn | input | 1 | Done |
| passPulse | output | 1 | One-cycle pulse: obligation met |
| failPulse | output | 1 | One-cycle pulse: obligation violated |
| active | output | 1 | An attempt is open |

## Verification
A wrong state shows at the ports within one cycle. A state that stays open when it should close keeps `active` high in the idle gap the bench places after every trace. A state that closes early drops `active` inside a trace. A write counter that is off by one moves the change from "write phase" to "obligation" by one cycle. The extra-write case then shows a missing fail pulse, or the last write shows a false fail. Each of these is visible in the cycle after the offending input.

// File: rtl/hsmon_pkg.sv
package hsmon_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_REQ,
    ST_WRITE,
    ST_CHECK
  } monState_t;

  typedef struct packed {
    logic cntClear;
    logic cntInc;
    logic passSet;
    logic failSet;
  } monStrobe_t;

endpackage

// File: rtl/hsmon_datapath.sv
module hsmon_datapath
  import hsmon_pkg::*;
#(
  parameter int WR_LEN = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  monStrobe_t stb,
  output logic       cntLast,
  output logic       passPulse,
  output logic       failPulse
);

  localparam int CW = $clog2(WR_LEN + 1);
  localparam logic [CW-1:0] LAST_VAL = CW'(WR_LEN - 1);

  logic [CW-1:0] wrCnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      wrCnt     <= '0;
      passPulse <= 1'b0;
      failPulse <= 1'b0;
    end else begin
      if (stb.cntClear) begin
        wrCnt <= '0;
      end else if (stb.cntInc) begin
        wrCnt <= wrCnt + CW'(1);
      end
      passPulse <= stb.passSet;
      failPulse <= stb.failSet;
    end
  end

  assign cntLast = (wrCnt == LAST_VAL);

endmodule

// File: rtl/hsmon_control.sv
module hsmon_control
  import hsmon_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       reqIn,
  input  logic       ackIn,
  input  logic       wrIn,
  input  logic       waitIn,
  input  logic       doneIn,
  input  logic       cntLast,
  output monStrobe_t stb,
  output logic       active
);

  monState_t curState, nextState;

  always_ff @(posedge clk) begin
    if (rst) curState <= ST_IDLE;
    else     curState <= nextState;
  end

  always_comb begin
    nextState = curState;
    stb       = '0;
    unique case (curState)
      ST_IDLE: begin
        if (reqIn) nextState = ST_REQ;
      end
      ST_REQ: begin
        if (ackIn) begin
          nextState    = ST_WRITE;
          stb.cntClear = 1'b1;
        end else if (!reqIn) begin
          nextState = ST_IDLE;
        end
      end
      ST_WRITE: begin
        if (!wrIn)        nextState = ST_IDLE;
        else if (cntLast) nextState = ST_CHECK;
        else              stb.cntInc = 1'b1;
      end
      ST_CHECK: begin
        if (doneIn) begin
          stb.passSet = 1'b1;
          nextState   = ST_IDLE;
        end else if (!(waitIn && !reqIn)) begin
          stb.failSet = 1'b1;
          nextState   = ST_IDLE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  assign active = (curState != ST_IDLE);

endmodule

// File: rtl/reqack_write_monitor.sv
module reqack_write_monitor
  import hsmon_pkg::*;
#(
  parameter int WR_LEN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic reqIn,
  input  logic ackIn,
  input  logic wrIn,
  input  logic waitIn,
  input  logic doneIn,
  output logic passPulse,
  output logic failPulse,
  output logic active
);

  monStrobe_t stb;
  logic       cntLast;

  hsmon_control u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .reqIn   (reqIn),
    .ackIn   (ackIn),
    .wrIn    (wrIn),
    .waitIn  (waitIn),
    .doneIn  (doneIn),
    .cntLast (cntLast),
    .stb     (stb),
    .active  (active)
  );

  hsmon_datapath #(.WR_LEN(WR_LEN)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .stb       (stb),
    .cntLast   (cntLast),
    .passPulse (passPulse),
    .failPulse (failPulse)
  );

endmodule

// File: rtl/hsmon_checker.sv
module hsmon_checker (
  input logic clk,
  input logic rst,
  input logic reqIn,
  input logic doneIn,
  input logic passPulse,
  input logic failPulse,
  input logic active
);

  // R1
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (!active && !passPulse && !failPulse));

  // R2
  open_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(active) |-> $past(reqIn));

  // R9
  no_pass_fail_chk: assert property (@(posedge clk) disable iff (rst)
    !(passPulse && failPulse));

  // R9
  verdict_closes_chk: assert property (@(posedge clk) disable iff (rst)
    (passPulse || failPulse) |-> !active);

  // R7
  pass_from_done_chk: assert property (@(posedge clk) disable iff (rst)
    passPulse |-> ($past(doneIn) && $past(active)));

  // R8
  fail_from_open_chk: assert property (@(posedge clk) disable iff (rst)
    failPulse |-> ($past(active) && !$past(doneIn)));

  // R9
  pass_single_chk: assert property (@(posedge clk) disable iff (rst)
    passPulse |=> !passPulse);

endmodule

bind reqack_write_monitor hsmon_checker u_chk (
  .clk       (clk),
  .rst       (rst),
  .reqIn     (reqIn),
  .doneIn    (doneIn),
  .passPulse (passPulse),
  .failPulse (failPulse),
  .active    (active)
);

// File: tb/sim_reqack_write_monitor.sv
`timescale 1ns/1ps
module sim_reqack_write_monitor;

  localparam int WRL = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reqIn = 1'b0, ackIn = 1'b0, wrIn = 1'b0, waitIn = 1'b0, doneIn = 1'b0;
  logic passPulse, failPulse, active;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  reqack_write_monitor #(.WR_LEN(WRL)) u0 (
    .clk(clk), .rst(rst), .reqIn(reqIn), .ackIn(ackIn), .wrIn(wrIn),
    .waitIn(waitIn), .doneIn(doneIn),
    .passPulse(passPulse), .failPulse(failPulse), .active(active)
  );

  task automatic checkOut(input logic eP, eF, eA, input string tag);
    checks++;
    if ({passPulse, failPulse, active} !== {eP, eF, eA}) begin
      errors++;
      $display("FAIL %s: pass/fail/active got %b%b%b expected %b%b%b",
               tag, passPulse, failPulse, active, eP, eF, eA);
    end
  endtask

  task automatic step(input logic r, a, w, wt, d,
                      input logic eP, eF, eA, input string tag);
    reqIn = r; ackIn = a; wrIn = w; waitIn = wt; doneIn = d;
    @(posedge clk);
    @(negedge clk);
    checkOut(eP, eF, eA, tag);
  endtask

  task automatic gap();
    step(0, 0, 0, 0, 0, 0, 0, 0, "R9");
  endtask

  // term: 0 done, 1 done+wait, 2 empty cycle, 3 wait with request
  task automatic runTrace(input int reqLen, input bit ackOk, input bit ackWithReq,
                          input int nWr, input bit reqInWr, input int nWait,
                          input int term);
    for (int i = 0; i < reqLen; i++) step(1, 0, 0, 0, 0, 0, 0, 1, "R2");
    if (!ackOk) begin
      step(0, 0, 0, 0, 0, 0, 0, 0, "R3");
      gap();
      return;
    end
    step(ackWithReq, 1, 0, 0, 0, 0, 0, 1, "R3");
    if (nWr < WRL) begin
      for (int i = 0; i < nWr; i++) step(reqInWr, 0, 1, 0, 0, 0, 0, 1, "R10");
      step(0, 0, 0, 0, 0, 0, 0, 0, "R4");
      gap();
      return;
    end
    for (int i = 0; i < WRL; i++) step(reqInWr, 0, 1, 0, 0, 0, 0, 1, "R4");
    if (nWr > WRL) begin
      step(0, 0, 1, 0, 0, 0, 1, 0, "R8");
      gap();
      return;
    end
    for (int i = 0; i < nWait; i++) step(0, 0, 0, 1, 0, 0, 0, 1, "R6");
    case (term)
      0: step(0, 0, 0, 0, 1, 1, 0, 0, (nWait == 0) ? "R5" : "R6");
      1: step(0, 0, 0, 1, 1, 1, 0, 0, "R7");
      2: step(0, 0, 0, 0, 0, 0, 1, 0, "R8");
      default: step(1, 0, 0, 1, 0, 0, 1, 0, "R8");
    endcase
    gap();
  endtask

  initial begin
    #(20 * 190000);
    errors++;
    $display("FAIL watchdog: run did not end, got timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    checkOut(0, 0, 0, "R1");
    rst = 1'b0;

    // R1: write alone in idle opens nothing
    step(0, 0, 1, 0, 0, 0, 0, 0, "R1");

    for (int l = 1; l <= 3; l++)
      for (int ok = 0; ok < 2; ok++)
        for (int ar = 0; ar < 2; ar++)
          for (int n = 0; n <= WRL + 1; n++)
            for (int rw = 0; rw < 2; rw++)
              for (int m = 0; m <= 2; m++)
                for (int t = 0; t < 4; t++)
                  runTrace(l, ok[0], ar[0], n, rw[0], m, t);

    // R1: reset in the middle of the write run
    step(1, 0, 0, 0, 0, 0, 0, 1, "R2");
    step(0, 1, 0, 0, 0, 0, 0, 1, "R3");
    step(0, 0, 1, 0, 0, 0, 0, 1, "R4");
    rst = 1'b1;
    step(0, 0, 1, 0, 0, 0, 0, 0, "R1");
    rst = 1'b0;
    step(0, 0, 1, 0, 0, 0, 0, 0, "R1");

    // R1: reset while done arrives in the obligation phase
    step(1, 0, 0, 0, 0, 0, 0, 1, "R2");
    step(0, 1, 0, 0, 0, 0, 0, 1, "R3");
    for (int i = 0; i < WRL; i++) step(0, 0, 1, 0, 0, 0, 0, 1, "R4");
    rst = 1'b1;
    step(0, 0, 0, 0, 1, 0, 0, 0, "R1");
    rst = 1'b0;
    gap();

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule